// File: doc/BRIEF.md
# Lane Electrical-Idle and Auto Low-Power Controller

This block decides, for each of four lanes, when the output must be forced to the idle level and when the lane may drop into a reduced-power state. Each lane supplies one squelch bit (1 = input swing above the threshold, 0 = below). Idle is declared after a short qualification window measured in clock cycles. Low power uses a second, longer window measured in ticks of a slow timebase. It is only available once the device has been active for a long qualification period and the low-power strap is high. Any sample above the threshold takes a lane out of both states on the next clock edge.

A slave strap turns off the squelch circuits of lanes 2 to 4. Lane 1's squelch bit then decides idle and low power for every lane. The block also samples a three-level threshold-select pin through two sense bits and turns it into a two-bit code for the analog comparators.

With a 125 MHz clock, the default parameters give a 24 ns idle window, 2 ticks for low-power entry and 250000 ticks for arming. With a 1 µs tick these match the 20 ns, 1 µs and 250 ms figures.

Top module: `lane_idle_lp_ctrl`

## Requirements
- R1: While reset is asserted, idle_force and lp_req are all 0, sq_en is all 1 and thr_code is 01.
- R2: A lane's idle_force rises on the IDLE_CYC-th consecutive clock edge that samples its effective squelch bit at 0, and not before.
- R3: A lane's idle_force falls on the first clock edge that samples its effective squelch bit at 1.
- R4: A single above-threshold sample restarts the idle window, so a new full run of IDLE_CYC low samples is needed.
- R5: Low power is armed only after ARM_TICKS tick pulses while active is high; a lane cannot raise lp_req before that.
- R6: Once armed, a lane raises lp_req on the LP_TICKS-th tick pulse sampled while its effective squelch bit stays 0; an above sample restarts this count.
- R7: lp_req of a lane falls on the first clock edge that samples its effective squelch bit at 1.
- R8: Dropping active clears every lp_req on the next edge and disarms, so the full ARM_TICKS count must run again.
- R9: With lp_strap low, every lp_req is 0 on the next edge. When the strap returns high while still qualified, low power comes back after LP_TICKS ticks.
- R10: With slave_strap high, sq_en becomes 0001 (only lane 1, bit 0) one edge later. sq_above[0] then drives the idle and low-power state of all lanes, and sq_above[3:1] are ignored.
- R11: thr_code is registered from the sense pair {thr_hi_sense, thr_lo_sense}: 00 gives 00 (low), 11 gives 10 (high), 10 or 01 gives 01 (open, default).
- R12: Without slave mode, each lane's idle state depends only on its own squelch bit, for every combination of the four bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse of the slow timebase |
| active | input | 1 | Device is past receiver detection |
| lp_strap | input | 1 | Enables automatic low power |
| slave_strap | input | 1 | Lanes 2-4 follow lane 1 squelch |
| sq_above | input | LANES | Per-lane squelch: 1 = signal above threshold |
| thr_hi_sense | input | 1 | Threshold pin sampled with weak pull-up |
| thr_lo_sense | input | 1 | Threshold pin sampled with weak pull-down |
| idle_force | output | LANES | Hold lane output at idle level |
| lp_req | output | LANES | Per-lane low-power request |
| sq_en | output | LANES | Per-lane squelch circuit enable |
| thr_code | output | 2 | Decoded threshold level |

## Verification
The hardest state to reach is a lane in low power, because it needs a long arming count and then a second count on a different timebase. The bench builds a small configuration (ARM_TICKS 4, LP_TICKS 2, IDLE_CYC 3) and drives tick pulses by hand, so it can stop one tick short of each boundary and check that the output has not yet moved. From the low-power state it then applies single-lane glitches, a strap drop, a loss of active and slave mode.

// File: rtl/lilp_pkg.sv
package lilp_pkg;
    typedef enum logic [1:0] {
        THR_LOW  = 2'b00,
        THR_MID  = 2'b01,
        THR_HIGH = 2'b10
    } thr_code_e;

    function automatic thr_code_e thr_decode(input logic hi_s, input logic lo_s);
        thr_code_e c;
        if (hi_s && lo_s)        c = THR_HIGH;
        else if (!hi_s && !lo_s) c = THR_LOW;
        else                     c = THR_MID;
        return c;
    endfunction
endpackage

// File: rtl/lilp_arm.sv
module lilp_arm #(
    parameter int ARM_TICKS = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic lp_strap,
    output logic armed
);
    localparam int AW = (ARM_TICKS > 1) ? $clog2(ARM_TICKS) : 1;
    localparam logic [AW-1:0] LAST = AW'(ARM_TICKS - 1);

    typedef struct packed {
        logic [AW-1:0] cnt;
        logic          done;
    } arm_st_t;

    arm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (tick && !st_q.done) begin
            if (st_q.cnt == LAST) st_d.done = 1'b1;
            else                  st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed = st_q.done & lp_strap & active;
endmodule

// File: rtl/lilp_lane.sv
module lilp_lane #(
    parameter int IDLE_CYC = 3,
    parameter int LP_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sq_hi,
    input  logic armed,
    output logic idle_o,
    output logic lp_o
);
    localparam int IW = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
    localparam int LW = (LP_TICKS > 1) ? $clog2(LP_TICKS) : 1;
    localparam logic [IW-1:0] I_LAST = IW'(IDLE_CYC - 1);
    localparam logic [LW-1:0] L_LAST = LW'(LP_TICKS - 1);

    typedef struct packed {
        logic [IW-1:0] icnt;
        logic          idle;
        logic [LW-1:0] lcnt;
        logic          lp;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // idle qualification, counted in clock cycles
        if (sq_hi) begin
            st_d.icnt = '0;
            st_d.idle = 1'b0;
        end else if (!st_q.idle) begin
            if (st_q.icnt == I_LAST) st_d.idle = 1'b1;
            else                     st_d.icnt = st_q.icnt + 1'b1;
        end
        // low-power qualification, counted in timebase ticks
        if (sq_hi || !armed) begin
            st_d.lcnt = '0;
            st_d.lp   = 1'b0;
        end else if (tick && !st_q.lp) begin
            if (st_q.lcnt == L_LAST) st_d.lp   = 1'b1;
            else                     st_d.lcnt = st_q.lcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle_o = st_q.idle;
    assign lp_o   = st_q.lp;
endmodule

// File: rtl/lilp_thr.sv
module lilp_thr
    import lilp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_sense,
    input  logic       lo_sense,
    output logic [1:0] code
);
    thr_code_e code_d, code_q;

    always_comb code_d = thr_decode(hi_sense, lo_sense);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= THR_MID;
        else        code_q <= code_d;
    end

    assign code = code_q;
endmodule

// File: rtl/lane_idle_lp_ctrl.sv
module lane_idle_lp_ctrl #(
    parameter int LANES     = 4,
    parameter int IDLE_CYC  = 3,
    parameter int LP_TICKS  = 2,
    parameter int ARM_TICKS = 250000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    input  logic             lp_strap,
    input  logic             slave_strap,
    input  logic [LANES-1:0] sq_above,
    input  logic             thr_hi_sense,
    input  logic             thr_lo_sense,
    output logic [LANES-1:0] idle_force,
    output logic [LANES-1:0] lp_req,
    output logic [LANES-1:0] sq_en,
    output logic [1:0]       thr_code
);
    localparam logic [LANES-1:0] EN_ALL    = '1;
    localparam logic [LANES-1:0] EN_MASTER = LANES'(1);

    typedef struct packed {
        logic [LANES-1:0] sq_en;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [LANES-1:0] eff_sq;
    logic             armed;

    always_comb begin
        st_d       = st_q;
        st_d.sq_en = slave_strap ? EN_MASTER : EN_ALL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.sq_en <= EN_ALL;
        else        st_q       <= st_d;
    end

    assign sq_en = st_q.sq_en;

    // lane 0 is the master; others follow it in slave mode
    assign eff_sq[0] = sq_above[0];
    for (genvar g = 1; g < LANES; g++) begin : g_sel
        assign eff_sq[g] = slave_strap ? sq_above[0] : sq_above[g];
    end

    lilp_arm #(.ARM_TICKS(ARM_TICKS)) u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .active   (active),
        .lp_strap (lp_strap),
        .armed    (armed)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lilp_lane #(.IDLE_CYC(IDLE_CYC), .LP_TICKS(LP_TICKS)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .sq_hi  (eff_sq[g]),
            .armed  (armed),
            .idle_o (idle_force[g]),
            .lp_o   (lp_req[g])
        );
    end

    lilp_thr u_thr (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_sense (thr_hi_sense),
        .lo_sense (thr_lo_sense),
        .code     (thr_code)
    );
endmodule

// File: rtl/lilp_chk.sv
module lilp_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active,
    input logic             lp_strap,
    input logic             slave_strap,
    input logic [LANES-1:0] sq_above,
    input logic [LANES-1:0] idle_force,
    input logic [LANES-1:0] lp_req,
    input logic [LANES-1:0] sq_en,
    input logic [1:0]       thr_code
);
    p_reset_vals_r1: assert property (@(posedge clk)
        !rst_n |=> (idle_force == '0 && lp_req == '0 && thr_code == 2'b01));

    p_no_lp_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (lp_req == '0));

    p_strap_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_strap |=> (lp_req == '0));

    p_slave_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slave_strap |=> (sq_en == LANES'(1)));

    p_slave_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_strap && sq_above[0]) |=> (idle_force == '0 && lp_req == '0));

    p_thr_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        thr_code != 2'b11);

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        p_idle_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!slave_strap && sq_above[g]) |=> !idle_force[g]);
        p_lp_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!slave_strap && sq_above[g]) |=> !lp_req[g]);
    end
endmodule

bind lane_idle_lp_ctrl lilp_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .lp_strap    (lp_strap),
    .slave_strap (slave_strap),
    .sq_above    (sq_above),
    .idle_force  (idle_force),
    .lp_req      (lp_req),
    .sq_en       (sq_en),
    .thr_code    (thr_code)
);

// File: tb/lane_idle_lp_ctrl_tb.sv
module lane_idle_lp_ctrl_tb;
    localparam int LANES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, active = 1'b0, lp_strap = 1'b0, slave_strap = 1'b0;
    logic [LANES-1:0] sq_above = '1;
    logic thr_hi_sense = 1'b1, thr_lo_sense = 1'b0;
    logic [LANES-1:0] idle_force, lp_req, sq_en;
    logic [1:0] thr_code;

    int n_chk = 0, n_bad = 0;
    int cyc_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lane_idle_lp_ctrl #(.LANES(LANES), .IDLE_CYC(3), .LP_TICKS(2), .ARM_TICKS(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .active(active),
        .lp_strap(lp_strap), .slave_strap(slave_strap), .sq_above(sq_above),
        .thr_hi_sense(thr_hi_sense), .thr_lo_sense(thr_lo_sense),
        .idle_force(idle_force), .lp_req(lp_req), .sq_en(sq_en), .thr_code(thr_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic tickn(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; cyc(1);
            tick = 1'b0; cyc(1);
        end
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc_cnt);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cyc(3);
        check("R1 idle", 32'(idle_force), 0);
        check("R1 lp", 32'(lp_req), 0);
        check("R1 sq_en", 32'(sq_en), 4'hF);
        check("R1 thr", 32'(thr_code), 2'b01);
        rst_n = 1'b1; cyc(2);

        // R2 entry timing on lane 0
        sq_above = 4'b1110; cyc(2);
        check("R2 early", 32'(idle_force), 0);
        cyc(1);
        check("R2 entry", 32'(idle_force), 4'b0001);
        // R3 exit
        sq_above = 4'b1111; cyc(1);
        check("R3 exit", 32'(idle_force), 0);
        // R4 glitch restarts window
        sq_above = 4'b1110; cyc(2);
        sq_above = 4'b1111; cyc(1);
        sq_above = 4'b1110; cyc(2);
        check("R4 restarted", 32'(idle_force), 0);
        cyc(1);
        check("R4 full run", 32'(idle_force), 4'b0001);
        sq_above = 4'b1111; cyc(1);

        // R12 exhaustive lane independence
        for (int p = 0; p < 16; p++) begin
            sq_above = 4'(p); cyc(3);
            check("R12 pattern", 32'(idle_force), 32'((~p) & 4'hF));
            sq_above = 4'hF; cyc(1);
            check("R3 release", 32'(idle_force), 0);
        end

        // R5 arming, R6 entry
        active = 1'b1; lp_strap = 1'b1; sq_above = 4'b0000;
        tickn(4);
        check("R5 not armed yet", 32'(lp_req), 0);
        tickn(1);
        check("R6 one tick", 32'(lp_req), 0);
        tickn(1);
        check("R6 entry", 32'(lp_req), 4'hF);

        // R7 exit on lane 2, then R6 restart
        sq_above = 4'b0100; cyc(1);
        check("R7 exit", 32'(lp_req), 4'b1011);
        sq_above = 4'b0000; tickn(1);
        check("R6 restart", 32'(lp_req), 4'b1011);
        tickn(1);
        check("R6 reentry", 32'(lp_req), 4'hF);

        // R9 strap
        lp_strap = 1'b0; cyc(1);
        check("R9 strap low", 32'(lp_req), 0);
        tickn(3);
        check("R9 stays off", 32'(lp_req), 0);
        lp_strap = 1'b1; tickn(1);
        check("R9 one tick", 32'(lp_req), 0);
        tickn(1);
        check("R9 back", 32'(lp_req), 4'hF);

        // R8 loss of active disarms
        active = 1'b0; cyc(1);
        check("R8 cleared", 32'(lp_req), 0);
        active = 1'b1; tickn(5);
        check("R8 rearm pending", 32'(lp_req), 0);
        tickn(1);
        check("R8 rearmed", 32'(lp_req), 4'hF);

        // R10 slave mode
        slave_strap = 1'b1; sq_above = 4'b0001; cyc(1);
        check("R10 sq_en", 32'(sq_en), 4'b0001);
        check("R10 lp follow", 32'(lp_req), 0);
        cyc(3);
        check("R10 others ignored", 32'(idle_force), 0);
        sq_above = 4'b1110; cyc(3);
        check("R10 idle follow", 32'(idle_force), 4'hF);
        tickn(2);
        check("R10 lp all", 32'(lp_req), 4'hF);
        slave_strap = 1'b0; sq_above = 4'hF; cyc(1);
        check("R10 release en", 32'(sq_en), 4'hF);
        check("R10 release idle", 32'(idle_force), 0);

        // R11 threshold decode
        for (int k = 0; k < 4; k++) begin
            thr_hi_sense = k[1]; thr_lo_sense = k[0]; cyc(1);
            check("R11 thr", 32'(thr_code),
                  (k == 0) ? 32'd0 : (k == 3) ? 32'd2 : 32'd1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule